// File: doc/BRIEF.md
# Write-Sets-Direction Port Bank

This block holds sixteen single-bit bidirectional ports. A bit-addressed serial register interface reaches them, one bit per access. Each port comes out of power-up reset as an input with its driver off. The first write to a port stores the written bit and turns on that port's driver. The port keeps driving until a hardware reset occurs or until software issues a reset command. There is no separate direction register: writing to a port is what makes it an output.

A read at a port address always returns the level present on the pin, whether the port is driving or not, and a read changes nothing. The upper nine ports share their pins with interrupt lines 7 to 15, which are assigned in reverse: interrupt 7 sits on port 15 and interrupt 15 on port 7. Those pin levels are always passed to the interrupt logic. Enabling or masking each interrupt is done elsewhere, and the mask has no effect on a pin's driver.

Top module: `port_bank`

## Requirements
- R1: While `rst_n` is low, and directly after it rises, `pin_oe` and `pin_out` are all zero.
- R2: A write (`sel`=1, `wr_en`=1) at address 16+n, for n from 0 to 15, sets `pin_out[n]` to `wr_data` and `pin_oe[n]` to 1 at the next rising clock edge. All other port bits keep their values.
- R3: When `sel`=1 and `addr` is 16 or above, `rd_hit` is 1 and `rd_data` equals `pin_in[addr-16]` in the same cycle. A read with `wr_en`=0 leaves `pin_out` and `pin_oe` unchanged.
- R4: Once a port is an output, it stays an output through later writes to any port address, including writes that change its data. Only R1 or R5 clears it.
- R5: A write of 0 at address 15 while `clk_mode`=1 clears every `pin_oe` bit at the next edge and leaves every `pin_out` bit unchanged.
- R6: A write of 1 at address 15, or a write of 0 at address 15 while `clk_mode`=0, leaves `pin_oe` and `pin_out` unchanged.
- R7: While `sel`=0, writes have no effect, `rd_hit` is 0 and `rd_data` is 0.
- R8: `irq_line[k]` equals `pin_in[15-k]` for k from 0 to 8, where bit k stands for interrupt 7+k. This holds whatever the direction of the port.
- R9: Writes at addresses 0 to 14 leave `pin_oe` and `pin_out` unchanged, whatever `clk_mode` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| sel | input | 1 | Chip select, active high |
| addr | input | 5 | Bit address of the access |
| wr_en | input | 1 | Write strobe for the current access |
| wr_data | input | 1 | Bit being written |
| clk_mode | input | 1 | Current value of the mode bit held at address 0 |
| pin_in | input | 16 | Level present on each port pin |
| rd_hit | output | 1 | High when the access falls on a port address |
| rd_data | output | 1 | Pin level of the addressed port |
| pin_out | output | 16 | Latched output data of each port |
| pin_oe | output | 16 | Driver enable of each port |
| irq_line | output | 9 | Pin levels passed to interrupts 7 to 15 |

## Verification
The assertions assume that `sel`, `addr`, `wr_en`, `wr_data` and `clk_mode` hold steady around the sampling edge. They also assume that the access inputs are all idle during the reset cycle, because the `$past` checks look one edge back. The bench changes every input on the falling edge and keeps `sel` and `wr_en` low while `rst_n` is asserted. It models each pin as the driven value when the driver is enabled and as an external level otherwise, so that a read of an output port gives back its latch.

// File: rtl/port_bank.sv
module port_bank #(
  parameter int NPORT   = 16,
  parameter int NSHARED = 9,
  localparam int IW = $clog2(NPORT),
  localparam int AW = IW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic [AW-1:0]     addr,
  input  logic              wr_en,
  input  logic              wr_data,
  input  logic              clk_mode,
  input  logic [NPORT-1:0]  pin_in,
  output logic              rd_hit,
  output logic              rd_data,
  output logic [NPORT-1:0]  pin_out,
  output logic [NPORT-1:0]  pin_oe,
  output logic [NSHARED-1:0] irq_line
);

  logic          wr_acc;
  logic          port_sel;
  logic [IW-1:0] idx;
  logic          soft_rst;

  assign wr_acc   = sel & wr_en;
  assign port_sel = sel & addr[AW-1];
  assign idx      = addr[IW-1:0];
  assign soft_rst = wr_acc & clk_mode & ~wr_data & (addr == AW'(NPORT - 1));

  assign rd_hit  = port_sel;
  assign rd_data = port_sel & pin_in[idx];

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    logic q_out, q_oe;
    logic hit;
    assign hit = wr_acc & addr[AW-1] & (idx == IW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_out <= 1'b0;
        q_oe  <= 1'b0;
      end else if (hit) begin
        q_out <= wr_data;
        q_oe  <= 1'b1;
      end else if (soft_rst) begin
        q_oe  <= 1'b0;
      end
    end

    assign pin_out[g] = q_out;
    assign pin_oe[g]  = q_oe;
  end

  for (genvar k = 0; k < NSHARED; k++) begin : g_shared
    assign irq_line[k] = pin_in[NPORT-1-k];
  end

  a_r2_write_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_en && addr[AW-1]) |=>
      (pin_oe[$past(idx)] && pin_out[$past(idx)] == $past(wr_data)));

  a_r2_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_en && addr[AW-1]) |=>
      ($countones(pin_out ^ $past(pin_out)) <= 1));

  a_r3_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !wr_en) |=> ($stable(pin_out) && $stable(pin_oe)));

  a_r4_oe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && wr_en && clk_mode && !wr_data && addr == AW'(NPORT - 1)) |=>
      ((pin_oe & $past(pin_oe)) == $past(pin_oe)));

  a_r5_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_en && clk_mode && !wr_data && addr == AW'(NPORT - 1)) |=>
      (pin_oe == '0 && $stable(pin_out)));

  a_r7_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> ($stable(pin_out) && $stable(pin_oe)));

  a_r9_low_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_en && !addr[AW-1] && addr != AW'(NPORT - 1)) |=>
      ($stable(pin_out) && $stable(pin_oe)));

  always_comb begin
    if (!sel) a_r7_no_read: assert (!rd_hit && !rd_data);
  end

endmodule

// File: tb/port_bank_bench.sv
module port_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel, wr_en, wr_data, clk_mode;
  logic [4:0]  addr;
  logic [15:0] ext;
  logic [15:0] pin_in;
  logic        rd_hit, rd_data;
  logic [15:0] pin_out, pin_oe;
  logic [8:0]  irq_line;

  logic [15:0] exp_out, exp_oe;
  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

  port_bank u_port_bank (
    .clk(clk), .rst_n(rst_n), .sel(sel), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .clk_mode(clk_mode), .pin_in(pin_in),
    .rd_hit(rd_hit), .rd_data(rd_data), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq_line(irq_line)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    chk({req, " oe"}, pin_oe, exp_oe);
    chk({req, " out"}, pin_out, exp_out);
  endtask

  task automatic wr(input logic [4:0] a, input logic d, input logic m, input logic s = 1'b1);
    @(negedge clk);
    sel = s; addr = a; wr_en = 1'b1; wr_data = d; clk_mode = m;
    @(negedge clk);
    sel = 1'b0; wr_en = 1'b0; wr_data = 1'b0; addr = '0;
  endtask

  task automatic rd(input logic [4:0] a, input logic s, output logic hit, output logic dat);
    @(negedge clk);
    sel = s; addr = a; wr_en = 1'b0;
    #1;
    hit = rd_hit; dat = rd_data;
    @(negedge clk);
    sel = 1'b0; addr = '0;
  endtask

  task automatic hw_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 during reset oe", pin_oe, 16'h0);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    exp_out = '0; exp_oe = '0;
    @(negedge clk);
    chk_state("R1 after reset");
  endtask

  task automatic t_read_inputs();
    logic h, d;
    ext = 16'hA5C3;
    for (int n = 0; n < 16; n++) begin
      rd(5'(16 + n), 1'b1, h, d);
      chk("R3 hit", {15'd0, h}, 16'd1);
      chk("R3 input level", {15'd0, d}, {15'd0, ext[n]});
    end
    chk_state("R3 read quiet");
  endtask

  task automatic t_writes();
    logic h, d;
    for (int n = 0; n < 16; n += 3) begin
      wr(5'(16 + n), n[0], 1'b0);
      exp_out[n] = n[0]; exp_oe[n] = 1'b1;
      chk_state("R2 write");
    end
    ext = ~16'hA5C3;
    for (int n = 0; n < 16; n += 3) begin
      rd(5'(16 + n), 1'b1, h, d);
      chk("R3 driven level", {15'd0, d}, {15'd0, exp_out[n]});
    end
    wr(5'd16, 1'b1, 1'b1);
    exp_out[0] = 1'b1;
    wr(5'd31, 1'b0, 1'b1);
    exp_out[15] = 1'b0;
    chk_state("R4 rewrite keeps output");
  endtask

  task automatic t_ignored();
    wr(5'd15, 1'b1, 1'b1);
    chk_state("R6 write one at 15");
    wr(5'd15, 1'b0, 1'b0);
    chk_state("R6 write zero without mode");
    for (int a = 0; a < 15; a++) wr(5'(a), a[0], 1'b1);
    chk_state("R9 low addresses");
  endtask

  task automatic t_deselected();
    logic h, d;
    wr(5'd20, 1'b1, 1'b1, 1'b0);
    wr(5'd15, 1'b0, 1'b1, 1'b0);
    chk_state("R7 writes while deselected");
    rd(5'd20, 1'b0, h, d);
    chk("R7 read while deselected", {14'd0, h, d}, 16'd0);
  endtask

  task automatic t_shared();
    ext = 16'h3C96;
    #1;
    for (int k = 0; k < 9; k++)
      chk("R8 interrupt line", {15'd0, irq_line[k]},
          {15'd0, (exp_oe[15-k] ? exp_out[15-k] : ext[15-k])});
  endtask

  task automatic t_soft_reset();
    logic h, d;
    wr(5'd15, 1'b0, 1'b1);
    exp_oe = '0;
    chk_state("R5 soft reset");
    rd(5'd31, 1'b1, h, d);
    chk("R5 port reads pin after soft reset", {15'd0, d}, {15'd0, ext[15]});
  endtask

  initial begin
    rst_n = 1'b0; sel = 1'b0; wr_en = 1'b0; wr_data = 1'b0; clk_mode = 1'b0;
    addr = '0; ext = '0; exp_out = '0; exp_oe = '0;
    hw_reset();
    t_read_inputs();
    t_writes();
    t_ignored();
    t_deselected();
    t_shared();
    t_soft_reset();
    t_shared();
    wr(5'd22, 1'b1, 1'b0);
    exp_out[6] = 1'b1; exp_oe[6] = 1'b1;
    chk_state("R2 write after soft reset");
    hw_reset();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule